// File: doc/BRIEF.md
# Text-Mode Character Pixel Generator

This block turns a character screen into a stream of 4-bit colour pixels. The screen is 45 cells wide and 40 cells tall. Each cell is 8 pixels wide and 12 scanlines tall, so the visible area is 360 by 480 pixels. A raster timing source outside the block supplies a pixel enable, a pixel column and a scanline number, one pixel per clock.

For each cell the block reads a 16-bit word from an internal synchronous cell store. The word holds a character code and a colour attribute. The block then uses the character code and the glyph row to read one 8-bit row from an internal glyph ROM. It loads that row into a parallel-in serial-out shift register and shifts it out one bit per pixel. Each bit selects either the foreground or the background nibble of the attribute.

The attribute is delayed through its own stage registers so that it reaches the colour multiplexer in the same cycle as the glyph row it belongs to. This prevents colour bleeding between neighbouring cells. A simple write port fills the cell store. Sync generation and arbitration of writes are left to the surrounding logic.

Top module: `txt_pix_gen`

## Requirements
- R1: While rst_ni is low, and after it is released until enabled pixels reach the output, pix_o is 0.
- R2: A cell word holds the character code in bits 15:8, the background colour in bits 7:4 and the foreground colour in bits 3:0. A glyph bit of 1 outputs the foreground colour and a glyph bit of 0 outputs the background colour.
- R3: The glyph ROM row for character c and glyph row r (0 to 11) is c XOR ((r*17) mod 256). Bit 7 of that row is the pixel whose column mod 8 is 0, and lower bits follow from left to right.
- R4: The pixel at column x and scanline y uses cell index (y/12)*45 + x/8 and glyph row y mod 12.
- R5: The colour for the inputs sampled at a rising edge appears on pix_o after the third rising edge, counted from and including that edge.
- R6: When adjacent cells have different attributes, each of the 8 pixels of a cell uses the colours of its own cell. There is no carry-over between cells.
- R7: A cycle with pix_en_i low produces 0 on pix_o.
- R8: Columns 360 and above, or scanlines 480 and above, produce 0 even when pix_en_i is high.
- R9: A write with wr_en_i high stores wr_data_i at cell index wr_row_i*45 + wr_col_i. A write with wr_col_i 45 or more, or wr_row_i 40 or more, is ignored.
- R10: An enabled run may start at any cell boundary after any number of blank cycles. Within a run the column steps by one on each clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Pixel clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| pix_en_i | input | 1 | Pixel enable from the raster timing source |
| col_i | input | 9 | Pixel column |
| line_i | input | 9 | Scanline number |
| wr_en_i | input | 1 | Cell store write strobe |
| wr_col_i | input | 6 | Cell column for the write |
| wr_row_i | input | 6 | Cell row for the write |
| wr_data_i | input | 16 | Cell word to write |
| pix_o | output | 4 | Colour of the current pixel |

## Verification
The hardest case to reach is the cell boundary. There the shift register is reloaded while the attribute of the previous cell is still in flight. A one-cycle skew between glyph and colour would show up only in the first or last pixel of a cell, and only when neighbouring attributes differ. The bench fills the whole cell store with a pattern whose attribute changes from cell to cell. It then scans complete lines and runs that start at interior cell boundaries, and compares every pixel 3 cycles after it was driven.

// File: rtl/txt_pkg.sv
package txt_pkg;
  localparam int TXT_COLS = 45;
  localparam int TXT_ROWS = 40;
  localparam int GLYPH_W  = 8;
  localparam int GLYPH_H  = 12;
  localparam int CHAR_W   = 8;
  localparam int CLR_W    = 4;
  localparam int CELL_W   = 2 * CHAR_W;

  // generated glyph contents: row r of char c = c ^ (r*17)
  function automatic logic [GLYPH_W-1:0] glyph_row(logic [CHAR_W-1:0] c, logic [3:0] r);
    logic [7:0] k;
    k = 8'(r) * 8'd17;
    return (32'(r) < GLYPH_H) ? GLYPH_W'(c ^ k) : '0;
  endfunction
endpackage

// File: rtl/txt_cell_ram.sv
module txt_cell_ram #(
  parameter int DEPTH = 1800,
  parameter int W     = 16,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk_i,
  input  logic          we_i,
  input  logic [AW-1:0] waddr_i,
  input  logic [W-1:0]  wdata_i,
  input  logic [AW-1:0] raddr_i,
  output logic [W-1:0]  rdata_o
);
  logic [W-1:0] mem [DEPTH];

  always_ff @(posedge clk_i) begin
    if (we_i) mem[waddr_i] <= wdata_i;
    rdata_o <= mem[raddr_i];
  end
endmodule

// File: rtl/txt_glyph_rom.sv
module txt_glyph_rom
  import txt_pkg::*;
(
  input  logic               clk_i,
  input  logic [CHAR_W-1:0]  char_i,
  input  logic [3:0]         row_i,
  output logic [GLYPH_W-1:0] bits_o
);
  always_ff @(posedge clk_i) bits_o <= glyph_row(char_i, row_i);
endmodule

// File: rtl/txt_piso.sv
module txt_piso
  import txt_pkg::*;
(
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               load_i,
  input  logic               en_i,
  input  logic [GLYPH_W-1:0] bits_i,
  input  logic [CHAR_W-1:0]  attr_i,
  output logic [GLYPH_W-1:0] sr_o,
  output logic [CHAR_W-1:0]  attr_o,
  output logic               en_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sr_o   <= '0;
      attr_o <= '0;
      en_o   <= 1'b0;
    end else begin
      en_o <= en_i;
      if (load_i) begin
        sr_o   <= bits_i;
        attr_o <= attr_i;
      end else begin
        sr_o <= sr_o << 1;
      end
    end
  end
endmodule

// File: rtl/txt_pix_gen.sv
module txt_pix_gen
  import txt_pkg::*;
#(
  parameter int COLS = TXT_COLS,
  parameter int ROWS = TXT_ROWS,
  localparam int XW  = $clog2(COLS * GLYPH_W),
  localparam int YW  = $clog2(ROWS * GLYPH_H),
  localparam int CXW = $clog2(COLS),
  localparam int CYW = $clog2(ROWS)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              pix_en_i,
  input  logic [XW-1:0]     col_i,
  input  logic [YW-1:0]     line_i,
  input  logic              wr_en_i,
  input  logic [CXW-1:0]    wr_col_i,
  input  logic [CYW-1:0]    wr_row_i,
  input  logic [CELL_W-1:0] wr_data_i,
  output logic [CLR_W-1:0]  pix_o
);
  localparam int CELLS = COLS * ROWS;
  localparam int AW    = $clog2(CELLS);
  localparam int IW    = $clog2(GLYPH_W);

  logic              active;
  logic [AW-1:0]     rd_addr, wr_addr;
  logic              wr_ok;
  logic [3:0]        grow_d, grow1;
  logic [IW-1:0]     idx1, idx2;
  logic              en1, en2;
  logic [CELL_W-1:0] cell_q;
  logic [GLYPH_W-1:0] glyph_q, sr_w;
  logic [CHAR_W-1:0] attr2, attr_w;
  logic              en_w, load_w;

  always_comb begin
    active  = pix_en_i && (col_i < XW'(COLS * GLYPH_W)) && (line_i < YW'(ROWS * GLYPH_H));
    rd_addr = active ? AW'((32'(line_i) / 32'(GLYPH_H)) * 32'(COLS) + (32'(col_i) >> IW)) : '0;
    grow_d  = 4'(32'(line_i) % 32'(GLYPH_H));
    wr_ok   = wr_en_i && (wr_col_i < CXW'(COLS)) && (wr_row_i < CYW'(ROWS));
    wr_addr = AW'(32'(wr_row_i) * 32'(COLS) + 32'(wr_col_i));
  end

  // stage 1: cell fetch in flight
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      grow1 <= '0;
      idx1  <= '0;
      en1   <= 1'b0;
    end else begin
      grow1 <= grow_d;
      idx1  <= col_i[IW-1:0];
      en1   <= active;
    end
  end

  txt_cell_ram #(.DEPTH(CELLS), .W(CELL_W)) u_ram (
    .clk_i   (clk_i),
    .we_i    (wr_ok),
    .waddr_i (wr_addr),
    .wdata_i (wr_data_i),
    .raddr_i (rd_addr),
    .rdata_o (cell_q)
  );

  txt_glyph_rom u_rom (
    .clk_i  (clk_i),
    .char_i (cell_q[CELL_W-1:CHAR_W]),
    .row_i  (grow1),
    .bits_o (glyph_q)
  );

  // stage 2: attribute held back one cycle to meet the glyph row
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      attr2 <= '0;
      idx2  <= '0;
      en2   <= 1'b0;
    end else begin
      attr2 <= cell_q[CHAR_W-1:0];
      idx2  <= idx1;
      en2   <= en1;
    end
  end

  assign load_w = en2 && (idx2 == '0);

  txt_piso u_piso (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (load_w),
    .en_i   (en2),
    .bits_i (glyph_q),
    .attr_i (attr2),
    .sr_o   (sr_w),
    .attr_o (attr_w),
    .en_o   (en_w)
  );

  assign pix_o = !en_w ? '0 :
                 sr_w[GLYPH_W-1] ? attr_w[CLR_W-1:0] : attr_w[CHAR_W-1:CLR_W];
endmodule

// File: rtl/txt_pix_gen_chk.sv
module txt_pix_gen_chk
  import txt_pkg::*;
#(
  parameter int COLS = TXT_COLS,
  parameter int ROWS = TXT_ROWS,
  localparam int XW  = $clog2(COLS * GLYPH_W),
  localparam int YW  = $clog2(ROWS * GLYPH_H)
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               pix_en_i,
  input logic [XW-1:0]      col_i,
  input logic [YW-1:0]      line_i,
  input logic [CLR_W-1:0]   pix_o,
  input logic               load_i,
  input logic [CHAR_W-1:0]  attr_i
);
  logic [1:0] warm;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          warm <= '0;
    else if (warm != 2'd3) warm <= warm + 2'd1;
  end

  // R7
  blank_out_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (warm == 2'd3 && !$past(pix_en_i, 3)) |-> pix_o == '0);

  // R8
  range_out_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (warm == 2'd3 && ($past(col_i, 3) >= XW'(COLS * GLYPH_W) ||
                      $past(line_i, 3) >= YW'(ROWS * GLYPH_H))) |-> pix_o == '0);

  // R6
  attr_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (warm != 2'd0 && !load_i) |=> $stable(attr_i));

  // R10
  col_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (warm != 2'd0 && pix_en_i && col_i[2:0] != 3'd0) |->
      ($past(pix_en_i) && col_i == $past(col_i) + XW'(1)));

  // R1
  always_comb begin
    if (!rst_ni) rst_out_chk: assert (pix_o == '0);
  end
endmodule

bind txt_pix_gen txt_pix_gen_chk #(.COLS(COLS), .ROWS(ROWS)) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .pix_en_i (pix_en_i),
  .col_i    (col_i),
  .line_i   (line_i),
  .pix_o    (pix_o),
  .load_i   (load_w),
  .attr_i   (attr_w)
);

// File: tb/txt_pix_gen_tb.sv
module txt_pix_gen_tb;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        pix_en_i = 1'b0;
  logic [8:0]  col_i = '0;
  logic [8:0]  line_i = '0;
  logic        wr_en_i = 1'b0;
  logic [5:0]  wr_col_i = '0;
  logic [5:0]  wr_row_i = '0;
  logic [15:0] wr_data_i = '0;
  logic [3:0]  pix_o;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  logic [15:0] shadow [1800];
  logic [3:0]  e0, e1, e2;
  bit          v0, v1, v2;
  string       t0, t1, t2, cur_tag;

  // {cell col[31:26], cell row[25:20], glyph row[19:16], char[15:8], attr[7:0]}
  localparam logic [31:0] VEC [8] = '{
    {6'd0,  6'd0,  4'd0,  8'hFF, 8'h5A},
    {6'd1,  6'd0,  4'd11, 8'h3C, 8'h12},
    {6'd44, 6'd0,  4'd5,  8'h00, 8'hF0},
    {6'd0,  6'd39, 4'd11, 8'h81, 8'h9C},
    {6'd44, 6'd39, 4'd0,  8'h00, 8'h34},
    {6'd22, 6'd20, 4'd6,  8'hA5, 8'h7E},
    {6'd7,  6'd13, 4'd3,  8'h41, 8'hC3},
    {6'd30, 6'd5,  4'd9,  8'hE7, 8'h00}
  };

  txt_pix_gen u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .pix_en_i(pix_en_i), .col_i(col_i), .line_i(line_i),
    .wr_en_i(wr_en_i), .wr_col_i(wr_col_i), .wr_row_i(wr_row_i), .wr_data_i(wr_data_i),
    .pix_o(pix_o)
  );

  always #4 clk = ~clk;

  function automatic logic [3:0] model(bit en, int x, int y);
    logic [15:0] w;
    logic [7:0]  g;
    if (!en || x >= 360 || y >= 480) return 4'h0;
    w = shadow[(y / 12) * 45 + x / 8];
    g = w[15:8] ^ 8'(((y % 12) * 17) & 255);
    return g[7 - (x % 8)] ? w[3:0] : w[7:4];
  endfunction

  task automatic check(string tag, logic [3:0] act, logic [3:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s pix_o=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic step(bit en, int x, int y);
    @(negedge clk);
    if (v2) check(t2, pix_o, e2);
    e2 = e1; v2 = v1; t2 = t1;
    e1 = e0; v1 = v0; t1 = t0;
    e0 = model(en, x, y); v0 = 1'b1; t0 = cur_tag;
    pix_en_i = en;
    col_i = 9'(x);
    line_i = 9'(y);
  endtask

  task automatic flush();
    for (int i = 0; i < 4; i++) step(1'b0, 0, 0);
  endtask

  task automatic wr(int cx, int cy, logic [15:0] d);
    @(negedge clk);
    wr_en_i = 1'b1;
    wr_col_i = 6'(cx);
    wr_row_i = 6'(cy);
    wr_data_i = d;
    if (cx < 45 && cy < 40) shadow[cy * 45 + cx] = d;
    @(negedge clk);
    wr_en_i = 1'b0;
  endtask

  task automatic run(int y, int first_cell, int ncells);
    for (int x = first_cell * 8; x < (first_cell + ncells) * 8; x++) step(1'b1, x, y);
    flush();
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    v0 = 0; v1 = 0; v2 = 0;
    e0 = 0; e1 = 0; e2 = 0;
    // R1: reset state
    repeat (3) @(negedge clk);
    check("R1 in reset", pix_o, 4'h0);
    rst_ni = 1'b1;
    @(negedge clk);
    check("R1 after reset", pix_o, 4'h0);

    // R9: fill the cell store with a varying pattern
    for (int i = 0; i < 1800; i++)
      wr(i % 45, i / 45, {8'(i * 7), 8'(i * 13 + 5)});

    cur_tag = "R7 idle";
    flush();

    // R2 R3 R4 R5: table walk, one cell per vector
    foreach (VEC[k]) begin
      wr(int'(VEC[k][31:26]), int'(VEC[k][25:20]), VEC[k][15:0]);
      cur_tag = $sformatf("R2/R3/R4/R5 vec%0d", k);
      run(int'(VEC[k][25:20]) * 12 + int'(VEC[k][19:16]), int'(VEC[k][31:26]), 1);
    end

    // R6: full lines with changing attributes across every boundary
    cur_tag = "R6 full line";
    run(100, 0, 45);
    run(479, 0, 45);

    // R10: runs starting at interior cell boundaries after gaps
    cur_tag = "R10 mid start";
    for (int g = 0; g < 5; g++) step(1'b0, 0, 0);
    run(233, 20, 3);
    run(7, 43, 2);

    // R7: enable low while pointing at lit cells
    cur_tag = "R7 blank";
    for (int x = 0; x < 16; x++) step(1'b0, x, 0);
    flush();

    // R8: out of range column and line with enable high
    cur_tag = "R8 col range";
    for (int x = 360; x < 376; x++) step(1'b1, x, 50);
    flush();
    cur_tag = "R8 line range";
    for (int x = 0; x < 16; x++) step(1'b1, x, 480);
    flush();

    // R9: out-of-range writes are ignored, in-range write lands
    wr(0, 1, 16'hFF6D);
    wr(45, 0, 16'h00EE);
    wr(63, 63, 16'h0011);
    wr(0, 40, 16'h0022);
    cur_tag = "R9 write range";
    run(12, 0, 1);
    run(12, 44, 1);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule